// File: doc/BRIEF.md
# PWM Timer Compare Output Unit

This block is an 8-bit timer/counter with a single compare channel that drives one waveform pin. A three-bit counting-scheme field selects one of four schemes: free-running normal counting, clear-on-match counting, single-slope fast PWM, or dual-slope phase-correct PWM. In the PWM schemes the upper bit of that field picks the period limit (TOP). A two-bit output-action field sets how the pin responds to compare matches and to TOP. The counter and the pin advance only on cycles where the clock-enable tick is high. Writes to the compare value and to the mode fields arrive on simple write strobes.

The meaning of the action field depends on the counting scheme. In fast PWM, one edge of the pin is set at TOP and the other at the compare match. In phase-correct PWM, the direction of counting at the match decides whether the pin is set or cleared. When the compare value equals TOP, the match is ignored and only the TOP action takes effect, so the pin can be held fully high or fully low. In the PWM schemes the compare value is double-buffered and reloads at TOP, so a write never produces a runt pulse. The pin is driven only when the action field connects it and the external direction bit is set.

Top module: `pwm_cmp_unit`

## Requirements
- R1: With action field 2'b00 the waveform is released: pin_oe and pin_out are 0 whatever the count.
- R2: In a PWM scheme, action field 2'b01 releases the pin when scheme bit 2 is 0. When scheme bit 2 is 1, it connects the pin and toggles it on each compare match.
- R3: In fast PWM (scheme bits [1:0] = 2'b11), the counter runs 0..TOP and wraps to 0. Action 2'b10 sets the pin at TOP and clears it on a match. Action 2'b11 clears it at TOP and sets it on a match.
- R4: In phase-correct PWM (scheme bits [1:0] = 2'b01), the counter runs 0..TOP..0 and reverses at each end. Action 2'b10 clears the pin on a match while counting up and sets it on a match while counting down. Action 2'b11 does the opposite.
- R5: In a PWM scheme with action 2'b1x, if the active compare value equals TOP the match is ignored. At TOP the pin is then set for action 2'b10 and cleared for 2'b11.
- R6: In the non-PWM schemes, the action on a match is as follows: 2'b01 toggles the pin, 2'b10 clears it and 2'b11 sets it. Scheme bits [1:0] = 2'b00 is normal counting with TOP = 0xFF. Scheme bits [1:0] = 2'b10 is clear-on-match, with TOP equal to the compare value.
- R7: pin_oe is high only when dir_en is high and the action field connects the pin. pin_out is 0 whenever pin_oe is 0, and otherwise equals the internal waveform level.
- R8: In PWM schemes a compare write is held in a buffer and becomes active only on a tick at TOP. In non-PWM schemes it is active from the next cycle.
- R9: The counter and the waveform level change only on cycles with tick high. TOP is 0xFF in PWM schemes with bit 2 clear, and equals the active compare value in PWM schemes with bit 2 set.
- R10: A synchronous reset clears the counter, the waveform level, both compare registers and both mode fields, and sets the direction to up. After reset pin_oe and pin_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Clock enable for counter and waveform |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value write data |
| mode_wr | input | 1 | Mode fields write strobe |
| om_wdata | input | 2 | Output-action field write data |
| wm_wdata | input | 3 | Counting-scheme field write data |
| dir_en | input | 1 | External direction bit for the pin |
| pin_out | output | 1 | Pin value |
| pin_oe | output | 1 | Pin output enable |

## Verification
A corrupted count, a wrong direction flag or a stale active compare value has no port of its own. It becomes visible at the next compare or TOP event, when pin_out moves one or more ticks away from the expected edge. At the longest, that is one full period: 256 ticks, or 510 ticks in phase-correct mode. A wrong output-enable decode is visible on pin_oe in the same cycle. Because every cycle is compared with a bench model, a single misplaced edge is reported in the cycle where it happens.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        OM_OFF = 2'b00,
        OM_TGL = 2'b01,
        OM_CLR = 2'b10,
        OM_SET = 2'b11
    } out_mode_e;

    typedef enum logic [1:0] {
        SC_NORMAL = 2'b00,
        SC_PC     = 2'b01,
        SC_CTC    = 2'b10,
        SC_FAST   = 2'b11
    } scheme_e;

    function automatic logic is_pwm(scheme_e s);
        return (s == SC_FAST) || (s == SC_PC);
    endfunction

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  scheme_e      scheme,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt_o,
    output logic         up_o
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         up;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick) begin
            if (scheme == SC_PC) begin
                if (top == ZERO) begin
                    s_d.cnt = ZERO;
                    s_d.up  = 1'b1;
                end else if (s_q.up) begin
                    if (s_q.cnt >= top) begin
                        s_d.cnt = top - ONE;
                        s_d.up  = 1'b0;
                    end else begin
                        s_d.cnt = s_q.cnt + ONE;
                    end
                end else begin
                    if (s_q.cnt == ZERO) begin
                        s_d.cnt = ONE;
                        s_d.up  = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt - ONE;
                    end
                end
            end else begin
                s_d.up  = 1'b1;
                s_d.cnt = (s_q.cnt >= top) ? ZERO : s_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.cnt <= '0;
            s_q.up  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;
    assign up_o  = s_q.up;

    // R9: the count holds on cycles without a tick
    a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_o));

    // R4: reaching TOP while counting up turns the direction around
    a_r4_turn_at_top: assert property (@(posedge clk) disable iff (rst)
        (tick && scheme == SC_PC && up_o && cnt_o == top && top != ZERO) |=> !up_o);

    // R3: fast PWM wraps to zero after TOP
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (tick && scheme == SC_FAST && cnt_o == top) |=> (cnt_o == ZERO));

endmodule

// File: rtl/pwm_cmp_reg.sv
module pwm_cmp_reg
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         at_top,
    input  logic         pwm_mode,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] live_o
);
    typedef struct packed {
        logic [W-1:0] hold;
        logic [W-1:0] live;
    } cmp_state_t;

    cmp_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr) begin
            s_d.hold = wdata;
        end
        if (!pwm_mode) begin
            s_d.live = s_d.hold;
        end else if (tick && at_top) begin
            s_d.live = s_q.hold;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign live_o = s_q.live;

    // R8: in PWM schemes the active value only moves on a tick at TOP
    a_r8_live_holds_in_pwm: assert property (@(posedge clk) disable iff (rst)
        (pwm_mode && !(tick && at_top)) |=> $stable(live_o));

    // R8: in non-PWM schemes a write is active on the next cycle
    a_r8_direct_outside_pwm: assert property (@(posedge clk) disable iff (rst)
        (!pwm_mode && wr) |=> (live_o == $past(wdata)));

endmodule

// File: rtl/pwm_wave_out.sv
module pwm_wave_out
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  scheme_e      scheme,
    input  logic         top_sel,
    input  out_mode_e    om,
    input  logic [W-1:0] cnt,
    input  logic         up,
    input  logic [W-1:0] live,
    input  logic [W-1:0] top,
    input  logic         dir_en,
    output logic         pin_out,
    output logic         pin_oe
);
    typedef struct packed {
        logic lvl;
    } wave_state_t;

    wave_state_t s_d, s_q;

    logic match, at_top, ign, pwm, lvl_top, connected;

    always_comb begin
        pwm     = is_pwm(scheme);
        match   = (cnt == live);
        at_top  = (cnt == top);
        ign     = (live == top);
        lvl_top = (om == OM_CLR);
        s_d     = s_q;
        if (tick) begin
            if (!pwm) begin
                if (match) begin
                    case (om)
                        OM_TGL:  s_d.lvl = ~s_q.lvl;
                        OM_CLR:  s_d.lvl = 1'b0;
                        OM_SET:  s_d.lvl = 1'b1;
                        default: s_d.lvl = s_q.lvl;
                    endcase
                end
            end else if (om == OM_TGL) begin
                if (top_sel && match) begin
                    s_d.lvl = ~s_q.lvl;
                end
            end else if (om != OM_OFF) begin
                if (scheme == SC_FAST) begin
                    if (at_top) begin
                        s_d.lvl = lvl_top;
                    end else if (match && !ign) begin
                        s_d.lvl = ~lvl_top;
                    end
                end else begin
                    if (ign) begin
                        if (at_top) begin
                            s_d.lvl = lvl_top;
                        end
                    end else if (match) begin
                        s_d.lvl = up ? ~lvl_top : lvl_top;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.lvl <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        connected = (om != OM_OFF) && !(pwm && om == OM_TGL && !top_sel);
        pin_oe    = connected && dir_en;
        pin_out   = pin_oe && s_q.lvl;
    end

    // R9: the waveform level holds without a tick
    a_r9_level_holds: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(s_q.lvl));

    // R7: the pin is never driven without the direction bit
    a_r7_oe_needs_dir: assert property (@(posedge clk) disable iff (rst)
        pin_oe |-> dir_en);

    // R7: an undriven pin reads zero
    a_r7_idle_low: assert property (@(posedge clk) disable iff (rst)
        !pin_oe |-> !pin_out);

    // R3: fast PWM with clear-on-match action is high after a TOP tick
    a_r3_fast_set_at_top: assert property (@(posedge clk) disable iff (rst)
        (tick && scheme == SC_FAST && om == OM_CLR && cnt == top) |=> s_q.lvl);

    // R5: compare equal to TOP in phase-correct clear action never clears
    a_r5_pc_full_high: assert property (@(posedge clk) disable iff (rst)
        (tick && scheme == SC_PC && om == OM_CLR && live == top && s_q.lvl) |=> s_q.lvl);

endmodule

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit
    import pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             mode_wr,
    input  logic [1:0]       om_wdata,
    input  logic [2:0]       wm_wdata,
    input  logic             dir_en,
    output logic             pin_out,
    output logic             pin_oe
);
    localparam logic [CNT_W-1:0] FULL = '1;

    typedef struct packed {
        logic [1:0] om;
        logic [2:0] wm;
    } mode_state_t;

    mode_state_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (mode_wr) begin
            m_d.om = om_wdata;
            m_d.wm = wm_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    scheme_e          scheme;
    out_mode_e        om;
    logic             top_sel, pwm_mode, at_top, up;
    logic [CNT_W-1:0] cnt, live, top;

    always_comb begin
        scheme   = scheme_e'(m_q.wm[1:0]);
        om       = out_mode_e'(m_q.om);
        top_sel  = m_q.wm[2];
        pwm_mode = is_pwm(scheme);
        top      = ((pwm_mode && top_sel) || scheme == SC_CTC) ? live : FULL;
        at_top   = (cnt == top);
    end

    pwm_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .scheme (scheme),
        .top    (top),
        .cnt_o  (cnt),
        .up_o   (up)
    );

    pwm_cmp_reg #(.W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .at_top   (at_top),
        .pwm_mode (pwm_mode),
        .wr       (cmp_wr),
        .wdata    (cmp_wdata),
        .live_o   (live)
    );

    pwm_wave_out #(.W(CNT_W)) u_wave (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .scheme  (scheme),
        .top_sel (top_sel),
        .om      (om),
        .cnt     (cnt),
        .up      (up),
        .live    (live),
        .top     (top),
        .dir_en  (dir_en),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    // R1: a released pin is never enabled
    a_r1_off_released: assert property (@(posedge clk) disable iff (rst)
        (m_q.om == 2'b00) |-> !pin_oe);

    // R10: the cycle after reset the pin is released
    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> (!pin_oe && !pin_out));

endmodule

// File: tb/pwm_cmp_unit_tb.sv
module pwm_cmp_unit_tb;
    logic       clk = 1'b0;
    logic       rst, tick, cmp_wr, mode_wr, dir_en;
    logic [7:0] cmp_wdata;
    logic [1:0] om_wdata;
    logic [2:0] wm_wdata;
    logic       pin_out, pin_oe;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    pwm_cmp_unit u_dut (
        .clk(clk), .rst(rst), .tick(tick), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .mode_wr(mode_wr), .om_wdata(om_wdata), .wm_wdata(wm_wdata),
        .dir_en(dir_en), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // bench model state
    logic [7:0] mb, ma, mc;
    logic       mu, mo;
    logic [1:0] mom;
    logic [2:0] mwm;

    function automatic bit f_pwm(logic [2:0] wm);
        return wm[1:0] == 2'b11 || wm[1:0] == 2'b01;
    endfunction

    function automatic logic [7:0] f_top(logic [2:0] wm, logic [7:0] act);
        if ((f_pwm(wm) && wm[2]) || wm[1:0] == 2'b10) return act;
        return 8'hFF;
    endfunction

    function automatic logic [1:0] f_exp(logic [1:0] om, logic [2:0] wm, logic lvl, logic dir);
        logic oe;
        oe = dir && om != 2'b00 && !(f_pwm(wm) && om == 2'b01 && !wm[2]);
        return {oe, oe && lvl};
    endfunction

    task automatic m_reset();
        mb = 0; ma = 0; mc = 0; mu = 1; mo = 0; mom = 0; mwm = 0;
    endtask

    task automatic m_step();
        logic [7:0] top, nb, na, nc;
        logic       nu, no, m, at, ig, hi;
        top = f_top(mwm, ma);
        nb = mb; na = ma; nc = mc; nu = mu; no = mo;
        if (tick) begin
            m  = (mc == ma);
            at = (mc == top);
            ig = (ma == top);
            hi = (mom == 2'b10);
            if (!f_pwm(mwm)) begin
                if (m && mom == 2'b01) no = ~mo;
                if (m && mom == 2'b10) no = 1'b0;
                if (m && mom == 2'b11) no = 1'b1;
            end else if (mom == 2'b01) begin
                if (mwm[2] && m) no = ~mo;
            end else if (mom != 2'b00) begin
                if (mwm[1:0] == 2'b11) begin
                    if (at) no = hi;
                    else if (m && !ig) no = ~hi;
                end else if (ig) begin
                    if (at) no = hi;
                end else if (m) begin
                    no = mu ? ~hi : hi;
                end
            end
            if (mwm[1:0] == 2'b01) begin
                if (top == 0) begin nc = 0; nu = 1; end
                else if (mu) begin
                    if (mc >= top) begin nc = top - 1; nu = 0; end
                    else nc = mc + 1;
                end else if (mc == 0) begin nc = 1; nu = 1; end
                else nc = mc - 1;
            end else begin
                nu = 1;
                nc = (mc >= top) ? 8'd0 : mc + 1;
            end
        end
        if (cmp_wr) nb = cmp_wdata;
        if (!f_pwm(mwm)) na = nb;
        else if (tick && mc == top) na = mb;
        mb = nb; ma = na; mc = nc; mu = nu; mo = no;
        if (mode_wr) begin mom = om_wdata; mwm = wm_wdata; end
    endtask

    task automatic check(string tag);
        logic [1:0] e;
        e = f_exp(mom, mwm, mo, dir_en);
        n_vec++;
        if ({pin_oe, pin_out} !== e) begin
            n_bad++;
            $display("FAIL %s: {oe,out} actual=%b expected=%b (t=%0t)", tag, {pin_oe, pin_out}, e, $time);
        end
    endtask

    // one clock: inputs are already set at a negedge
    task automatic step(string tag);
        m_step();
        @(posedge clk);
        @(negedge clk);
        cmp_wr = 0; mode_wr = 0;
        check(tag);
    endtask

    task automatic set_mode(logic [1:0] om, logic [2:0] wm, string tag);
        mode_wr = 1; om_wdata = om; wm_wdata = wm;
        step(tag);
    endtask

    task automatic set_cmp(logic [7:0] v, string tag);
        cmp_wr = 1; cmp_wdata = v;
        step(tag);
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    function automatic string tag_of();
        if (mom == 2'b00) return "R1";
        if (!f_pwm(mwm)) return "R6";
        if (mom == 2'b01) return "R2";
        if (ma == f_top(mwm, ma)) return "R5";
        if (mwm[1:0] == 2'b11) return "R3";
        return "R4";
    endfunction

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1; tick = 0; cmp_wr = 0; mode_wr = 0; dir_en = 1;
        cmp_wdata = 0; om_wdata = 0; wm_wdata = 0;
        m_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        check("R10");                       // R10: released after reset
        tick = 1;
        run(40, "R1");                      // R1: action 00 keeps pin released

        // R3: fast PWM, TOP 0xFF, both actions
        set_cmp(8'h40, "R3");
        set_mode(2'b10, 3'b011, "R3");
        run(600, "R3");
        set_mode(2'b11, 3'b011, "R3");
        run(600, "R3");

        // R4: phase-correct, both actions
        set_cmp(8'h30, "R4");
        set_mode(2'b11, 3'b001, "R4");
        run(800, "R4");
        set_mode(2'b10, 3'b001, "R4");
        run(800, "R4");

        // R5: compare equal to TOP
        set_cmp(8'hFF, "R5");
        run(600, "R5");
        set_mode(2'b10, 3'b011, "R5");
        run(600, "R5");
        set_mode(2'b11, 3'b111, "R5");
        set_cmp(8'h20, "R5");
        run(300, "R5");

        // R2: toggle action
        set_mode(2'b01, 3'b011, "R2");
        run(100, "R2");
        set_mode(2'b01, 3'b111, "R2");
        run(300, "R2");

        // R8: mid-period write in fast PWM takes effect at TOP
        set_mode(2'b10, 3'b011, "R8");
        set_cmp(8'h80, "R8");
        run(300, "R8");
        set_cmp(8'h10, "R8");
        run(600, "R8");

        // R6: non-PWM schemes
        set_mode(2'b01, 3'b010, "R6");
        set_cmp(8'h05, "R6");
        run(200, "R6");
        set_mode(2'b11, 3'b000, "R6");
        run(300, "R6");
        set_mode(2'b10, 3'b000, "R6");
        run(300, "R6");

        // R7: direction bit gates the pin
        set_mode(2'b10, 3'b011, "R7");
        for (int i = 0; i < 300; i++) begin
            dir_en = (i % 7) < 3;
            step("R7");
        end
        dir_en = 1;

        // R9: sparse ticks, TOP from compare in phase-correct
        set_mode(2'b01, 3'b101, "R9");
        set_cmp(8'h11, "R9");
        for (int i = 0; i < 1200; i++) begin
            tick = ($urandom % 2) == 0;
            step("R9");
        end

        // random mix
        for (int i = 0; i < 6000; i++) begin
            tick = ($urandom % 4) != 0;
            if ($urandom % 300 == 0) dir_en = ~dir_en;
            if ($urandom % 150 == 0) begin
                mode_wr  = 1;
                om_wdata = 2'($urandom);
                wm_wdata = 3'($urandom);
            end
            if ($urandom % 60 == 0) begin
                cmp_wr = 1;
                case ($urandom % 4)
                    0: cmp_wdata = 8'hFF;
                    1: cmp_wdata = 8'h00;
                    default: cmp_wdata = 8'($urandom);
                endcase
            end
            step(tag_of());
        end

        // R10: reset mid-run returns to released state
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_reset();
        check("R10");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule